// File: doc/BRIEF.md
# Relative-Displacement Operand Address Unit

This unit resolves the operand address of a memory-reference instruction on a 12-bit accumulator machine. It takes the instruction word, the address that instruction was fetched from, an optional second instruction word, and the read data of a synchronous memory port. It returns the final 12-bit operand address with a one-cycle done strobe. The read latency of that memory port is one cycle.

A single-word instruction reaches a location near itself. A magnitude, a sign and the instruction's own address form that location. A two-word instruction carries an absolute address in its second word. A literal form points at the word that follows the instruction. Either addressed form can go through one pointer word in memory. For a subroutine call the unit also writes the return address into the target word through the same memory port, and it offers the address at which the callee starts.

A memory-field tag travels with the request and comes back with the result, unchanged.

Top module: `opaddr_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `done`, `busy`, `mem_rd_en` and `mem_wr_en` are low and `op_addr` is zero.
- R2: Short form (`long_form`=0, `literal`=0) uses these bits: `instr[5:0]` is a magnitude, `instr[6]` is a sign (1 means subtract) and `instr[7]` selects indirect. With `instr[7]`=0 the operand address is `instr_addr` plus or minus the magnitude, and `done` is high in the cycle after the accept. A magnitude of zero gives `instr_addr` for either sign.
- R3: Relative address arithmetic wraps modulo 4096 in both directions.
- R4: Indirect addressing reads exactly one pointer word. In the accept cycle `mem_rd_en` is high and `mem_addr` holds the pointer location. In the next cycle no read is made. The word read becomes `op_addr`, and `done` goes high two cycles after the accept.
- R5: Long form (`long_form`=1) takes the location from `ext_word`. `instr[4]` selects indirect, and `instr[3]` drives `acc_k` (1 selects K, 0 selects J).
- R6: Literal form (`literal`=1) takes priority over `long_form`. It gives `instr_addr`+1 one cycle after the accept. It makes no memory read and ignores every indirect bit.
- R7: A call (`is_call`=1) writes to memory in its `done` cycle. `mem_wr_en` is high, `mem_addr` equals `op_addr`, and `mem_wdata` is the return address: `instr_addr`+1 for the short form and `instr_addr`+2 for the long form. `call_pc` equals `op_addr`+1.
- R8: `busy` is high in the pointer-read cycle of an indirect request and in the link-write cycle of a call. A `start` pulse while `busy` is high is ignored.
- R9: `field_in` is captured at the accept and is presented on `field_out` while `done` is high.
- R10: `acc_k` is 0 for the short and literal forms, whatever the instruction bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse; accepted when `busy` is low |
| instr | input | 12 | Instruction word |
| instr_addr | input | 12 | Address of the instruction |
| ext_word | input | 12 | Second instruction word (absolute address) |
| long_form | input | 1 | Two-word instruction |
| literal | input | 1 | Literal operand form |
| is_call | input | 1 | Subroutine call: write link word |
| field_in | input | 2 | Field tag passed through |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 12 | Memory address |
| mem_rdata | input | 12 | Memory read data, one cycle after the read |
| mem_wr_en | output | 1 | Memory write strobe (call link) |
| mem_wdata | output | 12 | Return address written at the target |
| busy | output | 1 | Request in progress; `start` ignored |
| done | output | 1 | Result valid strobe |
| op_addr | output | 12 | Resolved operand address |
| acc_k | output | 1 | Accumulator select, K when 1 |
| field_out | output | 2 | Field tag of the finished request |
| call_pc | output | 12 | Target plus one, the callee entry |

## Verification
The assertions assume that `mem_rdata` carries, in the cycle after a read strobe, the word for the address that was read. They also assume that `start` rises only after reset has been released. The bench memory model registers a computed pattern of the address on every read strobe, so that assumption always holds. All stimulus is driven on the falling clock edge once reset has been released. The bench offers `start` while `busy` is high only on purpose, to check that such a request is ignored.

// File: rtl/opaddr_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the operand address unit.
// Assumes: nothing beyond IEEE 1800-2017.
package opaddr_pkg;

    // Sequencer state: idle/complete, or waiting on the pointer word.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PTR  = 1'b1
    } seq_state_e;

    // Instruction addressing form, decoded from the request flags.
    typedef enum logic [1:0] {
        FORM_SHORT = 2'd0,
        FORM_LONG  = 2'd1,
        FORM_LIT   = 2'd2
    } form_e;

endpackage

// File: rtl/opaddr_calc.sv
`timescale 1ns/1ps
// Module: opaddr_calc
// Works out the first location a request names, whether that location is
// a pointer, the accumulator select and the return address.
// Purely combinational.
// Assumes: the word width equals the address width, and the sign bit and
// the indirect bit sit just above the magnitude in the short form.
module opaddr_calc
    import opaddr_pkg::*;
#(
    parameter int AW     = 12,
    parameter int DISP_W = 6,
    parameter int L_IND  = 4,
    parameter int L_ACC  = 3
) (
    input  logic [AW-1:0] instr,
    input  logic [AW-1:0] instr_addr,
    input  logic [AW-1:0] ext_word,
    input  logic          long_form,
    input  logic          literal,
    output logic [AW-1:0] loc,
    output logic          ind,
    output logic          acc_k,
    output logic [AW-1:0] ret_addr
);
    localparam int SIGN_BIT = DISP_W;
    localparam int S_IND    = DISP_W + 1;
    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] TWO = AW'(2);

    form_e         form;
    logic [AW-1:0] offs;
    logic [AW-1:0] rel_up;
    logic [AW-1:0] rel_dn;

    // Decode the form; literal wins over the long form.
    always_comb begin
        if (literal)        form = FORM_LIT;
        else if (long_form) form = FORM_LONG;
        else                form = FORM_SHORT;
    end

    // Zero-extended magnitude, and both relative sums (wrap mod 2**AW).
    assign offs   = {{(AW-DISP_W){1'b0}}, instr[DISP_W-1:0]};
    assign rel_up = instr_addr + offs;
    assign rel_dn = instr_addr - offs;

    // Pick the location, the indirect flag, the accumulator and the return address by form.
    always_comb begin
        case (form)
            FORM_LIT: begin
                loc      = instr_addr + ONE;
                ind      = 1'b0;
                acc_k    = 1'b0;
                ret_addr = instr_addr + TWO;
            end
            FORM_LONG: begin
                loc      = ext_word;
                ind      = instr[L_IND];
                acc_k    = instr[L_ACC];
                ret_addr = instr_addr + TWO;
            end
            default: begin
                loc      = instr[SIGN_BIT] ? rel_dn : rel_up;
                ind      = instr[S_IND];
                acc_k    = 1'b0;
                ret_addr = instr_addr + ONE;
            end
        endcase
    end

endmodule

// File: rtl/opaddr_seq.sv
`timescale 1ns/1ps
// Module: opaddr_seq
// Accepts requests. A direct request finishes in one cycle. An indirect
// request makes one pointer read and finishes in two. A call's link word
// is written in its done cycle.
// Assumes: the memory returns read data one cycle after mem_rd_en.
module opaddr_seq
    import opaddr_pkg::*;
#(
    parameter int AW = 12,
    parameter int FW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] loc,
    input  logic          ind,
    input  logic [AW-1:0] ret_addr,
    input  logic          acc_k_in,
    input  logic          is_call,
    input  logic [FW-1:0] field_in,
    input  logic [AW-1:0] mem_rdata,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_wdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] op_addr,
    output logic          acc_k,
    output logic [FW-1:0] field_out,
    output logic [AW-1:0] call_pc
);
    localparam logic [AW-1:0] ONE = AW'(1);

    seq_state_e    state_q;
    logic          done_q;
    logic          call_q;
    logic          acc_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] ret_q;
    logic [FW-1:0] fld_q;
    logic          accept;

    // Busy during the pointer wait and during a call's link write.
    assign busy   = (state_q == ST_PTR) | (done_q & call_q);
    assign accept = start & ~busy;

    // Request sequencing and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
            call_q  <= 1'b0;
            acc_q   <= 1'b0;
            addr_q  <= '0;
            ret_q   <= '0;
            fld_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        call_q <= is_call;
                        ret_q  <= ret_addr;
                        acc_q  <= acc_k_in;
                        fld_q  <= field_in;
                        if (ind) begin
                            state_q <= ST_PTR;
                        end else begin
                            addr_q <= loc;
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_PTR: begin
                    addr_q  <= mem_rdata;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Memory port: the pointer read in the accept cycle, the link write in the done cycle.
    assign mem_rd_en = accept & ind;
    assign mem_addr  = mem_rd_en ? loc : addr_q;
    assign mem_wr_en = done_q & call_q;
    assign mem_wdata = ret_q;

    // Result outputs.
    assign done      = done_q;
    assign op_addr   = addr_q;
    assign acc_k     = acc_q;
    assign field_out = fld_q;
    assign call_pc   = addr_q + ONE;

    // R4
    ptr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PTR) |=> (done && op_addr == $past(mem_rdata)));

    // R4
    rd_to_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (busy && !done && !mem_rd_en));

    // R7
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // R8
    ptr_nodone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PTR) |-> !done);

endmodule

// File: rtl/opaddr_unit.sv
`timescale 1ns/1ps
// Module: opaddr_unit (top)
// Operand address unit for a 12-bit accumulator machine. It handles short
// relative, long absolute and literal forms, single-level indirection and
// the subroutine-call link write.
// Assumes: a synchronous memory port with one-cycle read latency.
module opaddr_unit
    import opaddr_pkg::*;
#(
    parameter int AW     = 12,
    parameter int DISP_W = 6,
    parameter int FW     = 2,
    parameter int L_IND  = 4,
    parameter int L_ACC  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] instr,
    input  logic [AW-1:0] instr_addr,
    input  logic [AW-1:0] ext_word,
    input  logic          long_form,
    input  logic          literal,
    input  logic          is_call,
    input  logic [FW-1:0] field_in,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    input  logic [AW-1:0] mem_rdata,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_wdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] op_addr,
    output logic          acc_k,
    output logic [FW-1:0] field_out,
    output logic [AW-1:0] call_pc
);
    logic [AW-1:0] c_loc;
    logic          c_ind;
    logic          c_acc;
    logic [AW-1:0] c_ret;

    opaddr_calc #(
        .AW(AW), .DISP_W(DISP_W), .L_IND(L_IND), .L_ACC(L_ACC)
    ) u_calc (
        .instr      (instr),
        .instr_addr (instr_addr),
        .ext_word   (ext_word),
        .long_form  (long_form),
        .literal    (literal),
        .loc        (c_loc),
        .ind        (c_ind),
        .acc_k      (c_acc),
        .ret_addr   (c_ret)
    );

    opaddr_seq #(.AW(AW), .FW(FW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .loc       (c_loc),
        .ind       (c_ind),
        .ret_addr  (c_ret),
        .acc_k_in  (c_acc),
        .is_call   (is_call),
        .field_in  (field_in),
        .mem_rdata (mem_rdata),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .mem_wr_en (mem_wr_en),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .done      (done),
        .op_addr   (op_addr),
        .acc_k     (acc_k),
        .field_out (field_out),
        .call_pc   (call_pc)
    );

    // R2
    zero_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !long_form && !literal && !instr[DISP_W+1]
         && instr[DISP_W-1:0] == '0) |=> (done && op_addr == $past(instr_addr)));

    // R6
    lit_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && literal) |-> !mem_rd_en);

endmodule

// File: tb/opaddr_unit_test.sv
`timescale 1ns/1ps
module opaddr_unit_test;

    typedef struct packed {
        logic [11:0] instr;
        logic [11:0] iaddr;
        logic [11:0] ext;
        logic        lng;
        logic        lit;
        logic        ind;
        logic [11:0] loc;
        logic        acc;
    } vec_t;

    // Stimulus and expected first location; indirect entries expect pat(loc).
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{12'h505, 12'h200, 12'h000, 1'b0, 1'b0, 1'b0, 12'h205, 1'b0}, // R2 +5
        '{12'h47F, 12'h100, 12'h000, 1'b0, 1'b0, 1'b0, 12'h0C1, 1'b0}, // R2 -63
        '{12'h43F, 12'hFF0, 12'h000, 1'b0, 1'b0, 1'b0, 12'h02F, 1'b0}, // R3 up wrap
        '{12'h460, 12'h010, 12'h000, 1'b0, 1'b0, 1'b0, 12'hFF0, 1'b0}, // R3 down wrap
        '{12'h48A, 12'h300, 12'h000, 1'b0, 1'b0, 1'b1, 12'h30A, 1'b0}, // R4, R10
        '{12'h008, 12'h400, 12'hABC, 1'b1, 1'b0, 1'b0, 12'hABC, 1'b1}, // R5 K
        '{12'h010, 12'h400, 12'h123, 1'b1, 1'b0, 1'b1, 12'h123, 1'b0}, // R5 indirect
        '{12'h4FF, 12'h7FF, 12'h999, 1'b1, 1'b1, 1'b0, 12'h800, 1'b0}, // R6
        '{12'h040, 12'h555, 12'h000, 1'b0, 1'b0, 1'b0, 12'h555, 1'b0}, // R2 zero
        '{12'h4C5, 12'h002, 12'h000, 1'b0, 1'b0, 1'b1, 12'hFFD, 1'b0}  // R3, R4
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [11:0] instr, instr_addr, ext_word;
    logic        long_form, literal, is_call;
    logic [1:0]  field_in;
    logic        mem_rd_en, mem_wr_en, busy, done, acc_k;
    logic [11:0] mem_addr, mem_rdata, mem_wdata, op_addr, call_pc;
    logic [1:0]  field_out;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    opaddr_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .instr_addr(instr_addr), .ext_word(ext_word), .long_form(long_form),
        .literal(literal), .is_call(is_call), .field_in(field_in),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .busy(busy), .done(done),
        .op_addr(op_addr), .acc_k(acc_k), .field_out(field_out), .call_pc(call_pc)
    );

    // Memory content model: a computed word per address.
    function automatic logic [11:0] pat(input logic [11:0] a);
        return a * 12'd7 + 12'h135;
    endfunction

    // One-cycle-latency read port.
    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= pat(mem_addr);
    end

    task automatic chk(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [11:0] ins, adr, ext, input logic lng, lit, cl, input logic [1:0] fld);
        instr = ins; instr_addr = adr; ext_word = ext;
        long_form = lng; literal = lit; is_call = cl; field_in = fld;
        start = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        checks++; fails++;
        $display("FAIL watchdog actual=%h expected=%h", 12'h0, 12'h1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; mem_rdata = '0;
        drive(12'h0, 12'h0, 12'h0, 1'b0, 1'b0, 1'b0, 2'd0); start = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!done && !busy && !mem_wr_en, "R1 flags", {9'd0, done, busy, mem_wr_en}, 12'h0);
        chk(op_addr == 12'h0, "R1 op_addr", op_addr, 12'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !busy && !mem_rd_en, "R1 after release", {9'd0, done, busy, mem_rd_en}, 12'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [11:0] expv;
            drive(VECS[i].instr, VECS[i].iaddr, VECS[i].ext, VECS[i].lng, VECS[i].lit, 1'b0, 2'(i));
            #1;
            chk(mem_rd_en == VECS[i].ind, "R4/R6 read strobe", {11'd0, mem_rd_en}, {11'd0, VECS[i].ind});
            if (VECS[i].ind) chk(mem_addr == VECS[i].loc, "R4 pointer location", mem_addr, VECS[i].loc);
            @(negedge clk);
            start = 1'b0;
            if (VECS[i].ind) begin
                chk(busy && !done, "R8 busy in pointer wait", {10'd0, busy, done}, 12'h2);
                chk(!mem_rd_en, "R4 single level", {11'd0, mem_rd_en}, 12'h0);
                @(negedge clk);
                expv = pat(VECS[i].loc);
            end else begin
                expv = VECS[i].loc;
            end
            chk(done, "R2 done latency", {11'd0, done}, 12'h1);
            chk(op_addr == expv, "R2/R3/R4/R5/R6 op_addr", op_addr, expv);
            chk(acc_k == VECS[i].acc, "R5/R10 acc_k", {11'd0, acc_k}, {11'd0, VECS[i].acc});
            chk(field_out == 2'(i), "R9 field", {10'd0, field_out}, 12'(2'(i)));
            @(negedge clk);
            chk(!done, "R2 done pulse", {11'd0, done}, 12'h0);
        end

        // R7 short direct call, plus R8 start ignored in link cycle
        drive(12'h502, 12'h040, 12'h000, 1'b0, 1'b0, 1'b1, 2'd3);
        @(negedge clk);
        chk(done && mem_wr_en, "R7 link write strobe", {10'd0, done, mem_wr_en}, 12'h3);
        chk(mem_addr == 12'h042, "R7 link address", mem_addr, 12'h042);
        chk(mem_wdata == 12'h041, "R7 return short", mem_wdata, 12'h041);
        chk(call_pc == 12'h043, "R7 call_pc", call_pc, 12'h043);
        chk(busy, "R8 busy in link", {11'd0, busy}, 12'h1);
        drive(12'h505, 12'h600, 12'h000, 1'b0, 1'b0, 1'b0, 2'd0);
        @(negedge clk);
        start = 1'b0;
        chk(!done && op_addr == 12'h042, "R8 start ignored in link", op_addr, 12'h042);

        // R7 long indirect call
        @(negedge clk);
        drive(12'h010, 12'h600, 12'h200, 1'b1, 1'b0, 1'b1, 2'd2);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(op_addr == pat(12'h200), "R7 indirect target", op_addr, pat(12'h200));
        chk(mem_wr_en && mem_addr == pat(12'h200), "R7 link address ind", mem_addr, pat(12'h200));
        chk(mem_wdata == 12'h602, "R7 return long", mem_wdata, 12'h602);

        // R8 start during pointer wait is ignored
        @(negedge clk);
        drive(12'h48A, 12'h300, 12'h000, 1'b0, 1'b0, 1'b0, 2'd1);
        @(negedge clk);
        drive(12'h505, 12'h200, 12'h000, 1'b0, 1'b0, 1'b0, 2'd0);
        @(negedge clk);
        start = 1'b0;
        chk(done && op_addr == pat(12'h30A), "R8 result kept", op_addr, pat(12'h30A));
        @(negedge clk);
        chk(!done && op_addr == pat(12'h30A), "R8 start ignored in wait", op_addr, pat(12'h30A));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule